// File: doc/BRIEF.md
# UART Receive Error Status Register

This block keeps the receive-side error state of a UART. The receiver hands over each finished character on a one-cycle strobe, together with three per-character error indications: framing, parity and break. Characters wait in a 16-entry queue. A read of the data offset removes the oldest character and returns its byte along with its error bits and the overrun flag.

The same read copies the removed character's three error bits into a status register. Software therefore reads data first and status second, and the status always describes the character it has just taken, never the one now at the head of the queue. Overrun is handled separately. A character that arrives while the queue is full is thrown away, and the overrun flag is visible in the same cycle, without waiting for any read. It stays set until software clears it.

A write of any value to the status offset clears all four flags. The bus is a plain single-port register interface: an enable, a write select, a byte address and 32-bit data, with read data returned combinationally in the access cycle. The reset input is asynchronous and active low. The block releases its internal reset synchronously, so it leaves reset two clock edges after the input goes high.

Top module: `uart_rx_errstat`

## Requirements
- R1: After reset, a read of offset 0x004 returns 0 and a read of offset 0x000 returns 0.
- R2: Characters are returned by reads of offset 0x000 in arrival order, with the byte in bits 7:0, and up to 16 characters are held.
- R3: A data read word carries the character's framing flag in bit 8, its parity flag in bit 9 and its break flag in bit 10, plus the current overrun flag in bit 11; bits 31:12 are zero.
- R4: Status bits 0 (framing), 1 (parity) and 2 (break) show the flags of the character most recently removed by a data read. They do not change when a character arrives or when the status offset is read.
- R5: A character that arrives while 16 are held is discarded, even if a data read happens in the same cycle. Status bit 3 (overrun) reads 1 in that same cycle and stays 1 until cleared.
- R6: Any write to offset 0x004 clears status bits 3:0, whatever value is written. Status bits 31:8 always read zero.
- R7: A clear write in the same cycle as an overrun detection leaves overrun at 0. A data read in the same cycle as an overrun detection latches the removed character's flags and leaves overrun at 1.
- R8: A data read with nothing held returns 0 and changes no status bit. A write to offset 0x000, or any access to another offset, has no effect, and reads of other offsets return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | One-cycle strobe: a received character is present |
| rx_data | input | 8 | Received character byte |
| rx_frm_err | input | 1 | Framing error of the received character |
| rx_par_err | input | 1 | Parity error of the received character |
| rx_brk | input | 1 | Break condition seen on the received character |
| bus_en | input | 1 | Register access in this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset of the access |
| bus_wdata | input | 32 | Write data (value not used by the clear field) |
| bus_rdata | output | 32 | Read data, valid in the access cycle |

## Verification
Read data is combinational. The bench drives each access on a falling edge and samples `bus_rdata` one time unit later, in the same cycle, before the rising edge acts on it. Effects of a data read or a clear write on the status register are due at the next rising edge. They are therefore checked by a separate status read in a later cycle. The overrun flag is due in the very cycle of the offending arrival, so the bench checks it with a status read issued together with the extra character. The coincident cases, clear or data read in the detection cycle, are each driven in a single cycle and read back in the next one.

// File: rtl/uart_rxerr_pkg.sv
package uart_rxerr_pkg;

  typedef struct packed {
    logic       brk;
    logic       par;
    logic       frm;
    logic [7:0] data;
  } rx_char_t;

  localparam int unsigned OFS_DATA = 32'h000;
  localparam int unsigned OFS_STAT = 32'h004;

  // status bit positions
  localparam int unsigned ST_FRM = 0;
  localparam int unsigned ST_PAR = 1;
  localparam int unsigned ST_BRK = 2;
  localparam int unsigned ST_OVR = 3;

  // data word: flags start above the byte
  localparam int unsigned DW_FLAG_LSB = 8;

endpackage

// File: rtl/rxerr_rstsync.sv
module rxerr_rstsync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/rxerr_fifo.sv
module rxerr_fifo
  import uart_rxerr_pkg::*;
#(
  parameter int unsigned DEPTH = 16
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     push_req,
  input  rx_char_t push_entry,
  input  logic     pop,
  output rx_char_t head_entry,
  output logic     empty,
  output logic     full,
  output logic     ovr_det
);

  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

  rx_char_t         slot_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, wr_ptr_d;
  logic [PTR_W-1:0] rd_ptr_q, rd_ptr_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             push;
  logic             do_pop;

  assign full    = (cnt_q == CNT_FULL);
  assign empty   = (cnt_q == '0);
  // fullness is judged before any pop in the same cycle
  assign push    = push_req & ~full;
  assign ovr_det = push_req & full;
  assign do_pop  = pop & ~empty;

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    cnt_d    = cnt_q;
    if (push) begin
      wr_ptr_d = (wr_ptr_q == PTR_LAST) ? '0 : wr_ptr_q + 1'b1;
    end
    if (do_pop) begin
      rd_ptr_d = (rd_ptr_q == PTR_LAST) ? '0 : rd_ptr_q + 1'b1;
    end
    case ({push, do_pop})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (push) begin
        wr_ptr_q <= wr_ptr_d;
      end
      if (do_pop) begin
        rd_ptr_q <= rd_ptr_d;
      end
      if (push | do_pop) begin
        cnt_q <= cnt_d;
      end
    end
  end

  // storage: datapath only, no reset
  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (push && (wr_ptr_q == PTR_W'(i))) begin
        slot_q[i] <= push_entry;
      end
    end
  end

  assign head_entry = slot_q[rd_ptr_q];

endmodule

// File: rtl/rxerr_status.sv
module rxerr_status (
  input  logic clk,
  input  logic rst_n,
  input  logic pop,
  input  logic pop_frm,
  input  logic pop_par,
  input  logic pop_brk,
  input  logic ovr_det,
  input  logic clr,
  output logic frm_q,
  output logic par_q,
  output logic brk_q,
  output logic ovr_q,
  output logic ovr_live
);

  logic [2:0] chr_d;
  logic       chr_en;
  logic       ovr_d;
  logic       ovr_en;

  always_comb begin
    chr_en = pop | clr;
    // a popped character's flags win over a clear
    chr_d  = pop ? {pop_brk, pop_par, pop_frm} : 3'b000;
    ovr_en = clr | ovr_det;
    // a clear wins over a fresh detection
    ovr_d  = ~clr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frm_q <= 1'b0;
      par_q <= 1'b0;
      brk_q <= 1'b0;
      ovr_q <= 1'b0;
    end else begin
      if (chr_en) begin
        {brk_q, par_q, frm_q} <= chr_d;
      end
      if (ovr_en) begin
        ovr_q <= ovr_d;
      end
    end
  end

  // visible in the detection cycle itself
  assign ovr_live = ovr_q | ovr_det;

endmodule

// File: rtl/rxerr_bus.sv
module rxerr_bus
  import uart_rxerr_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned BUS_W  = 32
) (
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  rx_char_t          head_entry,
  input  logic              empty,
  input  logic              frm_q,
  input  logic              par_q,
  input  logic              brk_q,
  input  logic              ovr_live,
  output logic              pop,
  output logic              clr,
  output logic [BUS_W-1:0]  bus_rdata
);

  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(OFS_DATA);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);

  logic hit_data;
  logic hit_stat;
  logic rd_data;
  logic rd_stat;

  assign hit_data = bus_en & (bus_addr == A_DATA);
  assign hit_stat = bus_en & (bus_addr == A_STAT);
  assign rd_data  = hit_data & ~bus_we;
  assign rd_stat  = hit_stat & ~bus_we;
  assign pop      = rd_data & ~empty;
  assign clr      = hit_stat & bus_we;

  always_comb begin
    bus_rdata = '0;
    if (pop) begin
      bus_rdata[7:0]                  = head_entry.data;
      bus_rdata[DW_FLAG_LSB + ST_FRM] = head_entry.frm;
      bus_rdata[DW_FLAG_LSB + ST_PAR] = head_entry.par;
      bus_rdata[DW_FLAG_LSB + ST_BRK] = head_entry.brk;
      bus_rdata[DW_FLAG_LSB + ST_OVR] = ovr_live;
    end else if (rd_stat) begin
      bus_rdata[ST_FRM] = frm_q;
      bus_rdata[ST_PAR] = par_q;
      bus_rdata[ST_BRK] = brk_q;
      bus_rdata[ST_OVR] = ovr_live;
    end
  end

endmodule

// File: rtl/uart_rx_errstat.sv
module uart_rx_errstat
  import uart_rxerr_pkg::*;
#(
  parameter int unsigned DEPTH       = 16,
  parameter int unsigned ADDR_W      = 12,
  parameter int unsigned BUS_W       = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  input  logic              rx_frm_err,
  input  logic              rx_par_err,
  input  logic              rx_brk,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata
);

  logic     rst_sync_n;
  rx_char_t in_entry;
  rx_char_t head_entry;
  logic     empty;
  logic     full;
  logic     ovr_det;
  logic     pop;
  logic     clr;
  logic     frm_q;
  logic     par_q;
  logic     brk_q;
  logic     ovr_q;
  logic     ovr_live;
  logic     unused_wdata;

  // the clear field ignores the written value
  assign unused_wdata = ^bus_wdata;

  assign in_entry = '{brk: rx_brk, par: rx_par_err, frm: rx_frm_err, data: rx_data};

  rxerr_rstsync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  rxerr_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .push_req   (rx_valid),
    .push_entry (in_entry),
    .pop        (pop),
    .head_entry (head_entry),
    .empty      (empty),
    .full       (full),
    .ovr_det    (ovr_det)
  );

  rxerr_status u_stat (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .pop      (pop),
    .pop_frm  (head_entry.frm),
    .pop_par  (head_entry.par),
    .pop_brk  (head_entry.brk),
    .ovr_det  (ovr_det),
    .clr      (clr),
    .frm_q    (frm_q),
    .par_q    (par_q),
    .brk_q    (brk_q),
    .ovr_q    (ovr_q),
    .ovr_live (ovr_live)
  );

  rxerr_bus #(.ADDR_W(ADDR_W), .BUS_W(BUS_W)) u_bus (
    .bus_en     (bus_en),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .head_entry (head_entry),
    .empty      (empty),
    .frm_q      (frm_q),
    .par_q      (par_q),
    .brk_q      (brk_q),
    .ovr_live   (ovr_live),
    .pop        (pop),
    .clr        (clr),
    .bus_rdata  (bus_rdata)
  );

endmodule

// File: rtl/rxerr_chk.sv
module rxerr_chk #(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned BUS_W  = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rx_valid,
  input logic              bus_en,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [BUS_W-1:0]  bus_rdata,
  input logic              full,
  input logic              empty,
  input logic              pop,
  input logic              clr,
  input logic              frm_q,
  input logic              par_q,
  input logic              brk_q,
  input logic              ovr_q
);

  logic rd_stat;
  logic rd_data;
  assign rd_stat = bus_en && !bus_we && (bus_addr == ADDR_W'(4));
  assign rd_data = bus_en && !bus_we && (bus_addr == ADDR_W'(0));

  // R6
  stat_rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stat |-> (bus_rdata[BUS_W-1:8] == '0));

  // R8
  empty_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data && empty) |-> (bus_rdata == '0));

  // R5
  ovr_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stat && rx_valid && full) |-> bus_rdata[3]);

  // R5
  ovr_discard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && full && !pop) |=> full);

  // R4
  flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pop && !clr) |=> $stable({frm_q, par_q, brk_q}));

  // R6
  clear_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !pop) |=> !(frm_q || par_q || brk_q || ovr_q));

  // R7
  clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && rx_valid && full) |=> !ovr_q);

  // R5
  ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_q && !clr) |=> ovr_q);

endmodule

bind uart_rx_errstat rxerr_chk #(.ADDR_W(ADDR_W), .BUS_W(BUS_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .rx_valid  (rx_valid),
  .bus_en    (bus_en),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_rdata (bus_rdata),
  .full      (full),
  .empty     (empty),
  .pop       (pop),
  .clr       (clr),
  .frm_q     (frm_q),
  .par_q     (par_q),
  .brk_q     (brk_q),
  .ovr_q     (ovr_q)
);

// File: tb/tb_uart_rx_errstat.sv
`timescale 1ns/1ps
module tb_uart_rx_errstat;

  localparam logic [11:0] A_DATA = 12'h000;
  localparam logic [11:0] A_STAT = 12'h004;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        rx_valid;
  logic [7:0]  rx_data;
  logic        rx_frm_err, rx_par_err, rx_brk;
  logic        bus_en, bus_we;
  logic [11:0] bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [31:0] got;
  int          n_chk = 0;
  int          n_fail = 0;

  always #5 clk = ~clk;

  uart_rx_errstat dut (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_frm_err(rx_frm_err), .rx_par_err(rx_par_err), .rx_brk(rx_brk),
    .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic idle();
    rx_valid = 1'b0; bus_en = 1'b0; bus_we = 1'b0;
  endtask

  // each access: drive after falling edge, sample, let rising edge act
  task automatic finish_cycle();
    @(posedge clk); #1; idle();
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    finish_cycle();
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] v);
    @(negedge clk); bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = v;
    finish_cycle();
  endtask

  task automatic drive_rx(input logic [7:0] d, input logic [2:0] bpf);
    rx_valid = 1'b1; rx_data = d;
    {rx_brk, rx_par_err, rx_frm_err} = bpf;
  endtask

  task automatic push(input logic [7:0] d, input logic [2:0] bpf);
    @(negedge clk); drive_rx(d, bpf);
    finish_cycle();
  endtask

  // character arrival together with a bus access in one cycle
  task automatic push_access(input logic [7:0] d, input logic we, input logic [11:0] a,
                             input logic [31:0] v, output logic [31:0] r);
    @(negedge clk); drive_rx(d, 3'b000);
    bus_en = 1'b1; bus_we = we; bus_addr = a; bus_wdata = v;
    #1 r = bus_rdata;
    finish_cycle();
  endtask

  task automatic t_reset();
    rd(A_STAT, got); check("R1 status after reset", got, 32'h0);
    rd(A_DATA, got); check("R1 data after reset", got, 32'h0);
  endtask

  task automatic t_order_flags();
    push(8'hA5, 3'b001);
    push(8'h3C, 3'b010);
    push(8'h00, 3'b100);
    push(8'h5A, 3'b000);
    rd(A_STAT, got); check("R4 status ignores arrivals", got, 32'h0);
    rd(A_DATA, got); check("R2 R3 first char framing", got, 32'h1A5);
    rd(A_STAT, got); check("R4 status framing", got, 32'h1);
    rd(A_STAT, got); check("R4 status read does not pop", got, 32'h1);
    rd(A_DATA, got); check("R2 R3 second char parity", got, 32'h23C);
    rd(A_STAT, got); check("R4 status parity", got, 32'h2);
    rd(A_DATA, got); check("R2 R3 third char break", got, 32'h400);
    rd(A_STAT, got); check("R4 status break", got, 32'h4);
    rd(A_DATA, got); check("R2 fourth char clean", got, 32'h05A);
    rd(A_STAT, got); check("R4 status follows clean char", got, 32'h0);
  endtask

  task automatic t_clear();
    push(8'h77, 3'b111);
    rd(A_DATA, got); check("R3 all flags in data word", got, 32'h777);
    rd(A_STAT, got); check("R4 all flags latched", got, 32'h7);
    wr(A_STAT, 32'hDEADBEEF);
    rd(A_STAT, got); check("R6 clear with arbitrary value", got, 32'h0);
    push(8'h12, 3'b010);
    rd(A_DATA, got); check("R3 parity char", got, 32'h212);
    wr(A_STAT, 32'h0);
    rd(A_STAT, got); check("R6 clear with zero value", got, 32'h0);
  endtask

  task automatic t_overrun();
    for (int i = 0; i < 16; i++) push(8'(i * 3), 3'b000);
    rd(A_STAT, got); check("R5 no overrun at exactly 16", got, 32'h0);
    push_access(8'hEE, 1'b0, A_STAT, 32'h0, got);
    check("R5 overrun visible in detection cycle", got, 32'h8);
    rd(A_STAT, got); check("R5 overrun held", got, 32'h8);
    for (int i = 0; i < 16; i++) begin
      rd(A_DATA, got); check("R5 R3 contents kept, overrun bit 11", got, 32'h800 | 32'(i * 3));
    end
    rd(A_DATA, got); check("R5 R8 extra char discarded", got, 32'h0);
    rd(A_STAT, got); check("R5 overrun stays until cleared", got, 32'h8);
    wr(A_STAT, 32'hFFFFFFFF);
    rd(A_STAT, got); check("R6 overrun cleared", got, 32'h0);
  endtask

  task automatic t_coincide();
    push(8'h40, 3'b010);
    for (int i = 1; i < 16; i++) push(8'(8'h40 + i), 3'b000);
    push_access(8'h11, 1'b1, A_STAT, 32'h55, got);
    rd(A_STAT, got); check("R7 clear wins over detection", got, 32'h0);
    push_access(8'h22, 1'b0, A_DATA, 32'h0, got);
    check("R7 R5 pop with detection", got, 32'hA40);
    rd(A_STAT, got); check("R7 flags latched and overrun set", got, 32'hA);
    for (int i = 1; i < 16; i++) begin
      rd(A_DATA, got); check("R5 R2 drain after coincident cycles", got, 32'h800 | 32'(8'h40 + i));
    end
    rd(A_DATA, got); check("R5 R8 both late chars discarded", got, 32'h0);
    wr(A_STAT, 32'h1);
  endtask

  task automatic t_ignore();
    push(8'h42, 3'b100);
    rd(A_DATA, got); check("R3 break char", got, 32'h442);
    wr(A_DATA, 32'h000000FF);
    rd(A_STAT, got); check("R8 data write leaves status", got, 32'h4);
    rd(A_DATA, got); check("R8 empty read zero, no char from write", got, 32'h0);
    rd(A_STAT, got); check("R8 empty read leaves status", got, 32'h4);
    rd(12'h008, got); check("R8 other offset reads zero", got, 32'h0);
    wr(12'h008, 32'hFFFFFFFF);
    rd(A_STAT, got); check("R8 other offset write no effect", got, 32'h4);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; idle(); bus_addr = '0; bus_wdata = '0;
    rx_data = '0; rx_frm_err = 1'b0; rx_par_err = 1'b0; rx_brk = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(posedge clk);
    t_reset();
    t_order_flags();
    t_clear();
    t_overrun();
    t_coincide();
    t_ignore();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule